// File: doc/BRIEF.md
# I2C Bus Phase Timing Generator

This block turns phase requests from an I2C master's byte sequencer into exact SCL and SDA waveforms. The sequencer asks for one of four phases: a start condition from a released bus, a repeated start, a single data bit, or a stop condition. The block then drives the open-drain enables for both lines, where an enable of 1 pulls the line low. When the last count of the phase runs out, it raises a one-cycle done strobe. Every programmable duration is counted in prescaler ticks. One tick lasts (prescale+1) system clocks, and a count field of value N lasts N+1 ticks.

Two complete banks of the three timing words exist, one for fast mode and one for high-speed mode. A mode input chooses between them. The data-hold word is shared by both banks. After each SCL release the block waits a fixed 8 clocks plus twice the filter cycle count before it counts the high time. This models the delay that the input filter and synchroniser add. With this overhead, one data bit takes (prescale+1)·(low+high+2) + 8 + 2·filter system clocks. The block takes a copy of the selected bank, the data-hold word and the overhead when it accepts a request. Changes made to the inputs while a phase runs therefore take effect only from the next phase.

Top module: `i2c_phase_timer`

## Requirements
- R1: While reset is held and after it is released, scl_drive, sda_drive, busy and phase_done are all 0.
- R2: A tick is P = prescale+1 system clocks, and a count field of value N spans N+1 ticks. The segment's count starts when the segment starts.
- R3: A data bit (req_kind=2) holds SCL low for P·max(low+1, hold+setup) clocks. It then waits 8+2·filter clocks with SCL released, then holds SCL high for P·(high+1) clocks, and finishes with SCL driven low. With hold+setup ≤ low+1, the total is P·(low+high+2)+8+2·filter.
- R4: In data, stop and repeated-start phases, SDA takes its new value exactly P·hold clocks after the request is accepted. In a data bit, SDA never changes while SCL is released.
- R5: When hold+setup exceeds low+1, the low time grows to hold+setup ticks. SCL is then released setup ticks after the SDA change.
- R6: A start (req_kind=0) begins on a released bus. SDA is driven low P·(start setup+1) clocks after acceptance. SCL is driven low P·(start hold+1) clocks later, and the phase then ends.
- R7: A repeated start (req_kind=1) releases SDA after hold ticks. It releases SCL after max(release+1, hold+setup) ticks and waits the overhead. It then performs the start-setup and start-hold counts, and ends with both lines driven low.
- R8: A stop (req_kind=3) drives SDA low after hold ticks and releases SCL after the data low time. After the overhead and stop setup+1 ticks it releases SDA, and it ends with both lines released.
- R9: hs_sel=1 selects the high-speed words A–C, and hs_sel=0 selects the fast words. The data-hold word is the same in both modes. The mode, words and filter count are captured at acceptance and ignored for the rest of the phase.
- R10: Field positions: word A holds start setup [31:24], start hold [23:16] and stop setup [15:8]. Word B holds data setup [31:24], SCL low [15:8] and SCL high [7:0]. Word C holds the prescale value [23:16] and the repeated-start release [7:0]. The hold word holds data hold [7:0].
- R11: phase_done is a single-cycle pulse. It rises on the clock edge where the final count expires, and busy falls on that same edge.
- R12: A request that arrives while busy is 1 is ignored. A request presented in the cycle that phase_done is high is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_sel | input | 1 | 1 selects the high-speed timing bank |
| cfg_fs_a | input | 32 | Fast bank word A: start setup, start hold, stop setup |
| cfg_fs_b | input | 32 | Fast bank word B: data setup, SCL low, SCL high |
| cfg_fs_c | input | 32 | Fast bank word C: prescale, repeated-start release |
| cfg_hs_a | input | 32 | High-speed bank word A |
| cfg_hs_b | input | 32 | High-speed bank word B |
| cfg_hs_c | input | 32 | High-speed bank word C |
| cfg_hold | input | 32 | Shared data-hold word |
| filt_cnt | input | 3 | Filter cycle count used in the post-release overhead |
| req_valid | input | 1 | Phase request strobe, taken only when idle |
| req_kind | input | 2 | 0 start, 1 repeated start, 2 data bit, 3 stop |
| req_bit | input | 1 | Bit value for a data phase (1 releases SDA) |
| busy | output | 1 | A phase is in progress |
| scl_drive | output | 1 | Open-drain enable for SCL (1 pulls low) |
| sda_drive | output | 1 | Open-drain enable for SDA (1 pulls low) |
| phase_done | output | 1 | One-cycle strobe at the end of a phase |

## Verification
Two events can land in the same cycle: the done strobe that ends one phase, and the arrival of the next request. The bench presents a second data bit in exactly the cycle where phase_done is seen high. It then expects that bit's SDA change and total length to be measured from the very next edge, with no idle cycle inserted. A related collision is tested as well. A request injected while a phase is still running must leave that phase's length unchanged and must produce no later strobe. A mode flip made mid-phase must not alter the length already captured.

// File: rtl/i2c_phase_pkg.sv
`timescale 1ns/1ps
package i2c_phase_pkg;

    localparam int WORD_W = 32;
    localparam int FLD_W  = 8;
    localparam int SPAN_W = FLD_W + 1;

    typedef enum logic [1:0] {
        PH_START   = 2'd0,
        PH_RESTART = 2'd1,
        PH_DATA    = 2'd2,
        PH_STOP    = 2'd3
    } phase_kind_e;

    typedef enum logic [2:0] {
        SG_IDLE  = 3'd0,
        SG_LOW   = 3'd1,
        SG_OVH   = 3'd2,
        SG_HIGH  = 3'd3,
        SG_SHOLD = 3'd4
    } seg_e;

    typedef struct packed {
        logic [FLD_W-1:0] sta_su;
        logic [FLD_W-1:0] sta_hd;
        logic [FLD_W-1:0] sto_su;
        logic [FLD_W-1:0] dat_su;
        logic [FLD_W-1:0] dat_hd;
        logic [FLD_W-1:0] scl_lo;
        logic [FLD_W-1:0] scl_hi;
        logic [FLD_W-1:0] sr_rel;
        logic [FLD_W-1:0] prescale;
    } phase_cfg_t;

    // Last tick index of a low segment: it lasts max(base+1, hold+setup) ticks.
    function automatic logic [SPAN_W-1:0] low_last(input logic [FLD_W-1:0] base,
                                                   input logic [FLD_W-1:0] hold,
                                                   input logic [FLD_W-1:0] setup);
        logic [SPAN_W-1:0] a;
        logic [SPAN_W-1:0] b;
        a = {1'b0, base} + SPAN_W'(1);
        b = {1'b0, hold} + {1'b0, setup};
        return ((a > b) ? a : b) - SPAN_W'(1);
    endfunction

    // SDA drive level a phase aims for once the hold count has elapsed.
    function automatic logic target_drive(input phase_kind_e k, input logic bit_val);
        case (k)
            PH_DATA: return ~bit_val;
            PH_STOP: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/i2c_phase_cfg_sel.sv
`timescale 1ns/1ps
module i2c_phase_cfg_sel
    import i2c_phase_pkg::*;
#(
    parameter int FILT_W    = 3,
    parameter int FILT_MULT = 2,
    parameter int OVH_BASE  = 8,
    parameter int OVH_W     = 5
) (
    input  logic              hs_sel,
    input  logic [WORD_W-1:0] fs_a,
    input  logic [WORD_W-1:0] fs_b,
    input  logic [WORD_W-1:0] fs_c,
    input  logic [WORD_W-1:0] hs_a,
    input  logic [WORD_W-1:0] hs_b,
    input  logic [WORD_W-1:0] hs_c,
    input  logic [WORD_W-1:0] hold_w,
    input  logic [FILT_W-1:0] filt,
    output phase_cfg_t        cfg,
    output logic [OVH_W-1:0]  ovh
);

    logic [WORD_W-1:0] wa;
    logic [WORD_W-1:0] wb;
    logic [WORD_W-1:0] wc;

    assign wa = hs_sel ? hs_a : fs_a;
    assign wb = hs_sel ? hs_b : fs_b;
    assign wc = hs_sel ? hs_c : fs_c;

    always_comb begin
        cfg.sta_su   = wa[31:24];
        cfg.sta_hd   = wa[23:16];
        cfg.sto_su   = wa[15:8];
        cfg.dat_su   = wb[31:24];
        cfg.scl_lo   = wb[15:8];
        cfg.scl_hi   = wb[7:0];
        cfg.prescale = wc[23:16];
        cfg.sr_rel   = wc[7:0];
        cfg.dat_hd   = hold_w[7:0];
    end

    generate
        if (FILT_MULT == 2) begin : g_ovh_double
            assign ovh = OVH_W'(OVH_BASE) + OVH_W'({filt, 1'b0});
        end else begin : g_ovh_scaled
            assign ovh = OVH_W'(OVH_BASE) + OVH_W'(filt) * OVH_W'(FILT_MULT);
        end
    endgenerate

    logic unused_fields;
    assign unused_fields = ^{wa[7:0], wb[23:16], wc[31:24], wc[15:8], hold_w[31:8]};

endmodule

// File: rtl/i2c_phase_ticker.sv
`timescale 1ns/1ps
module i2c_phase_ticker #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] pcnt;

    assign tick = (pcnt == div);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/i2c_phase_seq.sv
`timescale 1ns/1ps
module i2c_phase_seq
    import i2c_phase_pkg::*;
#(
    parameter int OVH_BASE = 8,
    parameter int OVH_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_bit,
    input  phase_cfg_t       cfg_live,
    input  logic [OVH_W-1:0] ovh_live,
    input  logic             tick,
    output logic             seg_clear,
    output logic [FLD_W-1:0] prescale,
    output logic             busy,
    output logic             scl_drive,
    output logic             sda_drive,
    output logic             phase_done,
    output phase_kind_e      kind
);

    seg_e              seg_q;
    phase_kind_e       kind_q;
    phase_cfg_t        cfg_q;
    logic [OVH_W-1:0]  ovh_q;
    logic [SPAN_W-1:0] tcnt;
    logic [OVH_W-1:0]  ocnt;
    logic              tgt_q;
    logic              sda_q;
    logic              scl_q;
    logic              done_q;

    logic [SPAN_W-1:0] lim;
    logic [FLD_W-1:0]  low_base;
    logic              cnt_end;
    logic              ovh_end;
    logic              sda_now;

    always_comb begin
        low_base = (kind_q == PH_RESTART) ? cfg_q.sr_rel : cfg_q.scl_lo;
        case (seg_q)
            SG_LOW:   lim = low_last(low_base, cfg_q.dat_hd, cfg_q.dat_su);
            SG_HIGH: begin
                case (kind_q)
                    PH_DATA: lim = {1'b0, cfg_q.scl_hi};
                    PH_STOP: lim = {1'b0, cfg_q.sto_su};
                    default: lim = {1'b0, cfg_q.sta_su};
                endcase
            end
            SG_SHOLD: lim = {1'b0, cfg_q.sta_hd};
            default:  lim = '0;
        endcase
    end

    assign cnt_end   = tick && (tcnt == lim) &&
                       (seg_q == SG_LOW || seg_q == SG_HIGH || seg_q == SG_SHOLD);
    assign ovh_end   = (seg_q == SG_OVH) && (ocnt == ovh_q - OVH_W'(1));
    assign sda_now   = (tcnt >= {1'b0, cfg_q.dat_hd}) ? tgt_q : sda_q;
    assign seg_clear = (seg_q == SG_IDLE) || (seg_q == SG_OVH) || cnt_end;

    assign prescale   = cfg_q.prescale;
    assign busy       = (seg_q != SG_IDLE);
    assign scl_drive  = scl_q;
    assign sda_drive  = (seg_q == SG_LOW) ? sda_now : sda_q;
    assign phase_done = done_q;
    assign kind       = kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q  <= SG_IDLE;
            kind_q <= PH_START;
            cfg_q  <= '0;
            ovh_q  <= OVH_W'(OVH_BASE);
            tcnt   <= '0;
            ocnt   <= '0;
            tgt_q  <= 1'b0;
            sda_q  <= 1'b0;
            scl_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (seg_q)
                SG_IDLE: begin
                    if (req_valid) begin
                        kind_q <= phase_kind_e'(req_kind);
                        cfg_q  <= cfg_live;
                        ovh_q  <= ovh_live;
                        tcnt   <= '0;
                        ocnt   <= '0;
                        tgt_q  <= target_drive(phase_kind_e'(req_kind), req_bit);
                        seg_q  <= (phase_kind_e'(req_kind) == PH_START) ? SG_HIGH : SG_LOW;
                    end
                end
                SG_LOW: begin
                    if (tick) begin
                        if (cnt_end) begin
                            sda_q <= tgt_q;
                            scl_q <= 1'b0;
                            ocnt  <= '0;
                            tcnt  <= '0;
                            seg_q <= SG_OVH;
                        end else begin
                            tcnt <= tcnt + SPAN_W'(1);
                        end
                    end
                end
                SG_OVH: begin
                    if (ovh_end) begin
                        tcnt  <= '0;
                        seg_q <= SG_HIGH;
                    end else begin
                        ocnt <= ocnt + OVH_W'(1);
                    end
                end
                SG_HIGH: begin
                    if (tick) begin
                        if (cnt_end) begin
                            tcnt <= '0;
                            case (kind_q)
                                PH_DATA: begin
                                    scl_q  <= 1'b1;
                                    done_q <= 1'b1;
                                    seg_q  <= SG_IDLE;
                                end
                                PH_STOP: begin
                                    sda_q  <= 1'b0;
                                    done_q <= 1'b1;
                                    seg_q  <= SG_IDLE;
                                end
                                default: begin
                                    sda_q <= 1'b1;
                                    seg_q <= SG_SHOLD;
                                end
                            endcase
                        end else begin
                            tcnt <= tcnt + SPAN_W'(1);
                        end
                    end
                end
                SG_SHOLD: begin
                    if (tick) begin
                        if (cnt_end) begin
                            scl_q  <= 1'b1;
                            done_q <= 1'b1;
                            tcnt   <= '0;
                            seg_q  <= SG_IDLE;
                        end else begin
                            tcnt <= tcnt + SPAN_W'(1);
                        end
                    end
                end
                default: seg_q <= SG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2c_phase_timer.sv
`timescale 1ns/1ps
module i2c_phase_timer
    import i2c_phase_pkg::*;
#(
    parameter int FILT_W    = 3,
    parameter int FILT_MULT = 2,
    parameter int OVH_BASE  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_sel,
    input  logic [WORD_W-1:0] cfg_fs_a,
    input  logic [WORD_W-1:0] cfg_fs_b,
    input  logic [WORD_W-1:0] cfg_fs_c,
    input  logic [WORD_W-1:0] cfg_hs_a,
    input  logic [WORD_W-1:0] cfg_hs_b,
    input  logic [WORD_W-1:0] cfg_hs_c,
    input  logic [WORD_W-1:0] cfg_hold,
    input  logic [FILT_W-1:0] filt_cnt,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_bit,
    output logic              busy,
    output logic              scl_drive,
    output logic              sda_drive,
    output logic              phase_done
);

    localparam int OVH_MAX = OVH_BASE + FILT_MULT * ((1 << FILT_W) - 1);
    localparam int OVH_W   = $clog2(OVH_MAX + 1);

    phase_cfg_t       cfg_live;
    logic [OVH_W-1:0] ovh_live;
    logic [FLD_W-1:0] prescale;
    logic             seg_clear;
    logic             tick;
    phase_kind_e      cur_kind;

    i2c_phase_cfg_sel #(
        .FILT_W   (FILT_W),
        .FILT_MULT(FILT_MULT),
        .OVH_BASE (OVH_BASE),
        .OVH_W    (OVH_W)
    ) u_cfg (
        .hs_sel(hs_sel),
        .fs_a  (cfg_fs_a),
        .fs_b  (cfg_fs_b),
        .fs_c  (cfg_fs_c),
        .hs_a  (cfg_hs_a),
        .hs_b  (cfg_hs_b),
        .hs_c  (cfg_hs_c),
        .hold_w(cfg_hold),
        .filt  (filt_cnt),
        .cfg   (cfg_live),
        .ovh   (ovh_live)
    );

    i2c_phase_ticker #(
        .DIV_W(FLD_W)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clear(seg_clear),
        .div  (prescale),
        .tick (tick)
    );

    i2c_phase_seq #(
        .OVH_BASE(OVH_BASE),
        .OVH_W   (OVH_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_bit   (req_bit),
        .cfg_live  (cfg_live),
        .ovh_live  (ovh_live),
        .tick      (tick),
        .seg_clear (seg_clear),
        .prescale  (prescale),
        .busy      (busy),
        .scl_drive (scl_drive),
        .sda_drive (sda_drive),
        .phase_done(phase_done),
        .kind      (cur_kind)
    );

endmodule

// File: rtl/i2c_phase_timer_chk.sv
`timescale 1ns/1ps
module i2c_phase_timer_chk
    import i2c_phase_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        scl_drive,
    input logic        sda_drive,
    input logic        phase_done,
    input phase_kind_e kind
);

    // R11: strobe lasts one cycle and the block is idle while it shows
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        phase_done |=> !phase_done);
    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        phase_done |-> !busy);

    // R12: a running phase keeps the kind it was accepted with
    a_r12_kind_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(kind));

    // R4: SDA is frozen while SCL is released inside a data bit
    a_r4_sda_frozen_high: assert property (@(posedge clk) disable iff (rst)
        (busy && kind == PH_DATA && !scl_drive && $past(!scl_drive) && $past(busy))
            |-> $stable(sda_drive));

    // R3: a data bit ends with SCL pulled low
    a_r3_data_ends_low: assert property (@(posedge clk) disable iff (rst)
        (phase_done && kind == PH_DATA) |-> scl_drive);

    // R6, R7: start and repeated start end with both lines pulled low
    a_r6_start_ends_held: assert property (@(posedge clk) disable iff (rst)
        (phase_done && (kind == PH_START || kind == PH_RESTART)) |-> (scl_drive && sda_drive));

    // R8: stop leaves both lines released
    a_r8_stop_released: assert property (@(posedge clk) disable iff (rst)
        (phase_done && kind == PH_STOP) |-> (!scl_drive && !sda_drive));

endmodule

bind i2c_phase_timer i2c_phase_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .scl_drive (scl_drive),
    .sda_drive (sda_drive),
    .phase_done(phase_done),
    .kind      (cur_kind)
);

// File: tb/i2c_phase_timer_bench.sv
`timescale 1ns/1ps
module i2c_phase_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hs_sel = 1'b0;
    logic [31:0] cfg_fs_a, cfg_fs_b, cfg_fs_c, cfg_hs_a, cfg_hs_b, cfg_hs_c, cfg_hold;
    logic [2:0]  filt_cnt;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_bit = 1'b0;
    logic        busy, scl_drive, sda_drive, phase_done;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // fast bank fields
    int f_div = 1, f_ssu = 3, f_shd = 2, f_psu = 4, f_dsu = 2, f_lo = 5, f_hi = 4, f_sr = 3;
    // high-speed bank fields
    int h_div = 0, h_ssu = 1, h_shd = 1, h_psu = 2, h_dsu = 1, h_lo = 3, h_hi = 2, h_sr = 2;
    int hold = 2;
    int filt = 1;

    always #2.5 clk = ~clk;

    // R10: field placement inside the words
    always_comb begin
        cfg_fs_a = {8'(f_ssu), 8'(f_shd), 8'(f_psu), 8'h00};
        cfg_fs_b = {8'(f_dsu), 8'h00, 8'(f_lo), 8'(f_hi)};
        cfg_fs_c = {8'h00, 8'(f_div), 8'h00, 8'(f_sr)};
        cfg_hs_a = {8'(h_ssu), 8'(h_shd), 8'(h_psu), 8'h00};
        cfg_hs_b = {8'(h_dsu), 8'h00, 8'(h_lo), 8'(h_hi)};
        cfg_hs_c = {8'h00, 8'(h_div), 8'h00, 8'(h_sr)};
        cfg_hold = {24'h0, 8'(hold)};
        filt_cnt = 3'(filt);
    end

    i2c_phase_timer u_i2c_phase_timer (
        .clk(clk), .rst(rst), .hs_sel(hs_sel),
        .cfg_fs_a(cfg_fs_a), .cfg_fs_b(cfg_fs_b), .cfg_fs_c(cfg_fs_c),
        .cfg_hs_a(cfg_hs_a), .cfg_hs_b(cfg_hs_b), .cfg_hs_c(cfg_hs_c),
        .cfg_hold(cfg_hold), .filt_cnt(filt_cnt),
        .req_valid(req_valid), .req_kind(req_kind), .req_bit(req_bit),
        .busy(busy), .scl_drive(scl_drive), .sda_drive(sda_drive), .phase_done(phase_done)
    );

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int ovh_of(input int f);
        return 8 + 2 * f;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Issues one request at the current negedge and follows it to its strobe.
    // Times are counted in clock edges from the accepting edge (edge 0).
    task automatic drive_phase(input logic [1:0] kind, input logic b,
                               input int inj_k, input int flip_k,
                               output int total, output int t_sda, output int t_scl,
                               output int hi_chg);
        logic ps, pc;
        int k;
        bit seen;
        ps = sda_drive; pc = scl_drive;
        t_sda = -1; t_scl = -1; hi_chg = 0; total = -1; seen = 0;
        req_kind = kind; req_bit = b; req_valid = 1'b1;
        @(posedge clk);
        k = 0;
        @(negedge clk);
        req_valid = 1'b0;
        while (!seen && k < 3000) begin
            if (sda_drive != ps) begin
                if (t_sda < 0) t_sda = k;
                if (!scl_drive && !pc) hi_chg++;
            end
            if (scl_drive != pc && t_scl < 0) t_scl = k;
            ps = sda_drive; pc = scl_drive;
            if (phase_done) begin
                total = k;
                seen = 1;
                req_valid = 1'b0;
            end else begin
                req_valid = (k == inj_k);
                if (k == inj_k) req_kind = 2'd3;
                if (k == flip_k) hs_sel = ~hs_sel;
                @(posedge clk);
                k++;
                @(negedge clk);
            end
        end
        if (!seen) chk(0, "R11 phase never ended", k, 0);
    endtask

    task automatic t_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!scl_drive && !sda_drive, "R1 lines released in reset", {scl_drive, sda_drive}, 0);
        chk(!busy && !phase_done, "R1 idle in reset", {busy, phase_done}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !scl_drive && !sda_drive && !phase_done, "R1 idle after reset",
            {busy, scl_drive, sda_drive, phase_done}, 0);
    endtask

    task automatic t_start();
        int tot, ts, tc, hc, p;
        p = f_div + 1;
        drive_phase(2'd0, 1'b0, -1, -1, tot, ts, tc, hc);
        chk(ts == p * (f_ssu + 1), "R6 SDA falls after start setup", ts, p * (f_ssu + 1));
        chk(tot == p * (f_ssu + f_shd + 2), "R6 start length", tot, p * (f_ssu + f_shd + 2));
        chk(tc == tot, "R6 SCL falls at end of start", tc, tot);
        @(posedge clk);
        @(negedge clk);
        chk(!phase_done && !busy, "R11 strobe is one cycle", phase_done, 0);
    endtask

    task automatic t_data_fast(input logic b, input int exp_sda);
        int tot, ts, tc, hc, p, exp_tot;
        p = f_div + 1;
        exp_tot = p * (f_lo + f_hi + 2) + ovh_of(filt);
        drive_phase(2'd2, b, -1, -1, tot, ts, tc, hc);
        chk(tot == exp_tot, "R3 data bit period", tot, exp_tot);
        chk(ts == exp_sda, "R4 SDA change after hold", ts, exp_sda);
        chk(tc == p * (f_lo + 1), "R2 SCL release after low ticks", tc, p * (f_lo + 1));
        chk(hc == 0, "R4 SDA still while SCL released", hc, 0);
        chk(sda_drive == !b && scl_drive, "R3 data bit end state", {scl_drive, sda_drive}, {1'b1, !b});
    endtask

    task automatic t_stretch();
        int tot, ts, tc, hc, p, span, exp_tot;
        hold = 5; f_dsu = 3;
        p = f_div + 1;
        span = mx(f_lo + 1, hold + f_dsu);
        exp_tot = p * span + ovh_of(filt) + p * (f_hi + 1);
        @(negedge clk);
        drive_phase(2'd2, 1'b1, -1, -1, tot, ts, tc, hc);
        chk(ts == p * hold, "R5 SDA change after long hold", ts, p * hold);
        chk(tc - ts == p * f_dsu, "R5 setup kept before SCL release", tc - ts, p * f_dsu);
        chk(tot == exp_tot, "R5 stretched bit length", tot, exp_tot);
        hold = 2; f_dsu = 2;
        @(negedge clk);
    endtask

    task automatic t_stop();
        int tot, ts, tc, hc, p, exp_tot;
        p = f_div + 1;
        exp_tot = p * mx(f_lo + 1, hold + f_dsu) + ovh_of(filt) + p * (f_psu + 1);
        drive_phase(2'd3, 1'b0, -1, -1, tot, ts, tc, hc);
        chk(ts == p * hold, "R8 SDA pulled low after hold", ts, p * hold);
        chk(tc == p * (f_lo + 1), "R8 SCL released", tc, p * (f_lo + 1));
        chk(tot == exp_tot, "R8 stop length", tot, exp_tot);
        chk(!scl_drive && !sda_drive, "R8 both lines released", {scl_drive, sda_drive}, 0);
    endtask

    task automatic t_ignore_busy();
        int tot, ts, tc, hc, p, extra;
        p = f_div + 1;
        drive_phase(2'd0, 1'b0, 3, -1, tot, ts, tc, hc);
        chk(tot == p * (f_ssu + f_shd + 2), "R12 busy request leaves start length", tot,
            p * (f_ssu + f_shd + 2));
        extra = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (busy || phase_done) extra++;
        end
        chk(extra == 0, "R12 busy request not queued", extra, 0);
        chk(scl_drive && sda_drive, "R12 lines untouched by ignored request",
            {scl_drive, sda_drive}, 3);
    endtask

    task automatic t_restart();
        int tot, ts, tc, hc, p, low, exp_tot;
        p = f_div + 1;
        low = p * mx(f_sr + 1, hold + f_dsu);
        exp_tot = low + ovh_of(filt) + p * (f_ssu + f_shd + 2);
        drive_phase(2'd1, 1'b0, -1, -1, tot, ts, tc, hc);
        chk(ts == p * hold, "R7 SDA released after hold", ts, p * hold);
        chk(tc == low, "R7 SCL released after release count", tc, low);
        chk(tot == exp_tot, "R7 repeated start length", tot, exp_tot);
        chk(scl_drive && sda_drive, "R7 ends with both lines low", {scl_drive, sda_drive}, 3);
    endtask

    task automatic t_back_to_back();
        int tot, ts, tc, hc, p, exp_tot;
        p = f_div + 1;
        exp_tot = p * (f_lo + f_hi + 2) + ovh_of(filt);
        drive_phase(2'd2, 1'b1, -1, -1, tot, ts, tc, hc);
        chk(tot == exp_tot, "R3 first bit length", tot, exp_tot);
        // still in the strobe cycle: present the next bit now
        drive_phase(2'd2, 1'b0, -1, -1, tot, ts, tc, hc);
        chk(ts == p * hold, "R12 request in strobe cycle accepted at once", ts, p * hold);
        chk(tot == exp_tot, "R12 second bit length", tot, exp_tot);
    endtask

    task automatic t_hs(input logic b, input int f, input int flip_k, input string tag);
        int tot, ts, tc, hc, p, exp_tot;
        hs_sel = 1'b1; filt = f;
        @(negedge clk);
        p = h_div + 1;
        exp_tot = p * mx(h_lo + 1, hold + h_dsu) + ovh_of(f) + p * (h_hi + 1);
        drive_phase(2'd2, b, -1, flip_k, tot, ts, tc, hc);
        chk(ts == p * hold, {tag, " shared hold in fast-bank-free mode"}, ts, p * hold);
        chk(tot == exp_tot, {tag, " high-speed bit length"}, tot, exp_tot);
        hs_sel = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_start();
        t_data_fast(1'b1, (f_div + 1) * hold);
        t_data_fast(1'b0, (f_div + 1) * hold);
        t_stretch();
        t_stop();
        t_ignore_busy();
        t_restart();
        t_back_to_back();
        t_hs(1'b1, 1, -1, "R9");
        t_hs(1'b0, 3, -1, "R9 R2");
        t_hs(1'b1, 3, 1, "R9 captured");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        finished = 1;
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            fails++;
            $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule